// File: doc/BRIEF.md
# Smart-Card Character Receiver with NACK Limiting

This block receives characters from a smart card over a single shared, open-drain style line, in the half-duplex T=0 character format. A character is a low start bit, the data bits least significant first, and an even-parity bit. The block runs from an oversampling tick supplied by an external baud generator, with `OVS` ticks per elementary time unit (ETU). It finds the middle of each bit, rebuilds the character, and checks its parity.

When parity fails, the block asks the sender to repeat the character. It does this by pulling the line low during the guard time that follows the parity bit. Two options change this behaviour:

- **Inhibit mode** stores bad characters silently and never pulls the line.
- **Limiting mode** caps how many NACKs are sent in a row. When the cap is reached, the next bad character is accepted as if it were good, and a sticky iteration flag is raised.

The transmitter and the baud generator are outside this block.

Top module: `sc_char_rx`

## Requirements
- R1: While reset is held and after it is released with the line idle high, `driveLow`, `rxValid`, `parityErr` and `iterFlag` are 0 and `rxData` is 0.
- R2: A frame is: a low start bit, `DATA_W` data bits least significant first, and a parity bit chosen so that the data plus parity bits hold an even number of ones. Each bit lasts `OVS` ticks. When a frame with correct parity arrives, `rxData` takes the data bits, `rxValid` pulses high for exactly one clock, and the line is not driven.
- R3: A low pulse on the idle line that is back high at the midpoint of the start bit (`OVS/2` ticks after it was detected) is discarded. It produces no `rxValid`, no line drive and no change of `rxData`.
- R4: A character with wrong parity, in the plain case (inhibit off, and limiting off or below its cap), gets a NACK. `driveLow` is held high for exactly `NACK_TICKS` ticks, starting about half an ETU after the parity bit is sampled, which is roughly one ETU after the parity bit begins. No `rxValid` is given and `rxData` is unchanged.
- R5: `parityErr` is set by every character with wrong parity and stays set until `statusClr` is high at a clock edge. If a setting event and `statusClr` fall in the same clock, the flag ends up set.
- R6: With `inhibitNack` = 1, a character with wrong parity is written to `rxData` without an `rxValid` pulse and without any line drive, and the successive-NACK count is left unchanged. Inhibit takes priority over limiting.
- R7: With `limitEn` = 1, a bad character arriving when the count of successive NACKs is at least `maxIter` is accepted instead. It gets no NACK, `rxData` takes its data, `rxValid` pulses, `iterFlag` is set and the count returns to 0. The count rises by one for each NACK sent and saturates at all ones.
- R8: A character with correct parity returns the successive-NACK count to 0, so the cap counts NACKs only since the last good character.
- R9: `iterFlag` is sticky. It is cleared by `statusClr`, and a forced acceptance in the same clock as `statusClr` leaves it set.
- R10: With `limitEn` = 1 and `maxIter` = 0, the first bad character is accepted at once, with no NACK.
- R11: With `limitEn` = 0, every bad character gets a NACK, however many came before it and whatever `maxIter` holds.
- R12: All bit and NACK timing is counted in ticks. Slowing the tick to one pulse every two clocks doubles every duration and leaves the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling tick, `OVS` per ETU |
| lineIn | input | 1 | Shared line level as seen at the pad |
| limitEn | input | 1 | Enable the successive-NACK cap |
| inhibitNack | input | 1 | Store bad characters silently and never NACK |
| maxIter | input | ITER_W | Cap on successive NACKs per character |
| statusClr | input | 1 | Clear strobe for `parityErr` and `iterFlag` |
| rxData | output | DATA_W | Last stored character |
| rxValid | output | 1 | One-clock ready strobe |
| parityErr | output | 1 | Sticky parity-error flag |
| iterFlag | output | 1 | Sticky flag: cap reached and character forced through |
| driveLow | output | 1 | 1 pulls the shared line low (NACK) |

## Verification
The collision that matters is a status clear landing in the same clock as the evaluation that sets `parityErr` and `iterFlag`. The bench provokes it by holding `statusClr` high across a whole forced-acceptance character (limiting on, cap 0, bad parity). It drops the strobe at the first negative edge where `rxValid` shows, so the setting edge is the last one with the clear still applied. The bench reads both flags at that moment and requires them to be 1, which a design that lets the clear win would fail.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftBit;   // sample the line into the frame register
    logic evaluate;   // decide the fate of the complete frame
  } srxStrobes_t;

  typedef enum logic [2:0] {
    ST_RECOVER,
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_EVAL,
    ST_GUARD,
    ST_NACK
  } srxState_t;

  typedef enum logic [1:0] {
    OUT_ACCEPT,   // parity good
    OUT_SILENT,   // parity bad, stored without ready
    OUT_FORCED,   // parity bad, cap reached, accepted
    OUT_REJECT    // parity bad, NACK requested
  } rxOutcome_t;

endpackage

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
  import sc_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int NACK_TICKS = 16,
  parameter int DATA_W     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        lineS,
  input  logic        nackReq,
  output srxStrobes_t strobes,
  output logic        driveLow
);

  localparam int HALF    = OVS / 2;
  localparam int CNT_MAX = (NACK_TICKS > OVS) ? NACK_TICKS : OVS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = $clog2(DATA_W + 1);

  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] ETU_END  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] NACK_END = CNT_W'(NACK_TICKS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);  // parity bit

  srxState_t        stateQ, stateNx;
  logic [CNT_W-1:0] cntQ, cntNx;
  logic [IDX_W-1:0] idxQ, idxNx;
  logic             pendQ, pendNx;

  always_comb begin
    stateNx = stateQ;
    cntNx   = cntQ;
    idxNx   = idxQ;
    pendNx  = pendQ;
    strobes = '0;
    case (stateQ)
      ST_RECOVER: begin
        // wait until the line is released before arming start detection
        cntNx = '0;
        if (lineS) stateNx = ST_IDLE;
      end
      ST_IDLE: begin
        cntNx = '0;
        if (tick && !lineS) stateNx = ST_START;
      end
      ST_START: begin
        if (tick) begin
          if (cntQ == HALF_END) begin
            cntNx   = '0;
            idxNx   = '0;
            stateNx = lineS ? ST_IDLE : ST_BITS;  // reject short glitches
          end else begin
            cntNx = cntQ + 1'b1;
          end
        end
      end
      ST_BITS: begin
        if (tick) begin
          if (cntQ == ETU_END) begin
            cntNx            = '0;
            strobes.shiftBit = 1'b1;
            if (idxQ == LAST_IDX) stateNx = ST_EVAL;
            else                  idxNx   = idxQ + 1'b1;
          end else begin
            cntNx = cntQ + 1'b1;
          end
        end
      end
      ST_EVAL: begin
        strobes.evaluate = 1'b1;
        pendNx           = nackReq;
        cntNx            = '0;
        stateNx          = ST_GUARD;
      end
      ST_GUARD: begin
        // finish the second half of the parity bit
        if (tick) begin
          if (cntQ == HALF_END) begin
            cntNx   = '0;
            stateNx = pendQ ? ST_NACK : ST_RECOVER;
          end else begin
            cntNx = cntQ + 1'b1;
          end
        end
      end
      ST_NACK: begin
        if (tick) begin
          if (cntQ == NACK_END) begin
            cntNx   = '0;
            stateNx = ST_RECOVER;
          end else begin
            cntNx = cntQ + 1'b1;
          end
        end
      end
      default: stateNx = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_RECOVER;
      cntQ     <= '0;
      idxQ     <= '0;
      pendQ    <= 1'b0;
      driveLow <= 1'b0;
    end else begin
      stateQ   <= stateNx;
      cntQ     <= cntNx;
      idxQ     <= idxNx;
      pendQ    <= pendNx;
      driveLow <= (stateNx == ST_NACK);
    end
  end

endmodule

// File: rtl/sc_rx_datapath.sv
module sc_rx_datapath
  import sc_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ITER_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  srxStrobes_t       strobes,
  input  logic              limitEn,
  input  logic              inhibitNack,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              statusClr,
  output logic              lineS,
  output logic              nackReq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              parityErr,
  output logic              iterFlag
);

  localparam logic [ITER_W-1:0] CNT_SAT = {ITER_W{1'b1}};

  // Input synchronizer, depth picked by parameter
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= lineIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate
  assign lineS = syncQ[SYNC_STAGES-1];

  // Frame register: data bits then parity, filled from the top
  logic [DATA_W:0]     frameQ;
  logic [DATA_W-1:0]   dataBits;
  logic                parOk;
  logic [ITER_W-1:0]   nackCntQ;
  logic                limitHit;
  rxOutcome_t          outcome;

  assign dataBits = frameQ[DATA_W-1:0];
  assign parOk    = ~^frameQ;
  assign limitHit = limitEn && (nackCntQ >= maxIter);

  always_comb begin
    if (parOk)            outcome = OUT_ACCEPT;
    else if (inhibitNack) outcome = OUT_SILENT;
    else if (limitHit)    outcome = OUT_FORCED;
    else                  outcome = OUT_REJECT;
  end

  assign nackReq = strobes.evaluate && (outcome == OUT_REJECT);

  logic perrSet, iterSet;
  assign perrSet = strobes.evaluate && !parOk;
  assign iterSet = strobes.evaluate && (outcome == OUT_FORCED);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ   <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      nackCntQ <= '0;
    end else begin
      rxValid <= 1'b0;
      if (strobes.shiftBit) frameQ <= {lineS, frameQ[DATA_W:1]};
      if (strobes.evaluate) begin
        case (outcome)
          OUT_ACCEPT, OUT_FORCED: begin
            rxData   <= dataBits;
            rxValid  <= 1'b1;
            nackCntQ <= '0;
          end
          OUT_SILENT: rxData <= dataBits;
          default: begin
            if (nackCntQ != CNT_SAT) nackCntQ <= nackCntQ + 1'b1;
          end
        endcase
      end
    end
  end

  // Sticky flags: a set in the same clock as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      iterFlag  <= 1'b0;
    end else begin
      if (perrSet)        parityErr <= 1'b1;
      else if (statusClr) parityErr <= 1'b0;
      if (iterSet)        iterFlag  <= 1'b1;
      else if (statusClr) iterFlag  <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int NACK_TICKS  = 16,
  parameter int ITER_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              lineIn,
  input  logic              limitEn,
  input  logic              inhibitNack,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              statusClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              parityErr,
  output logic              iterFlag,
  output logic              driveLow
);

  srxStrobes_t strobes;
  logic        lineS;
  logic        nackReq;

  sc_rx_ctrl #(
    .OVS(OVS), .NACK_TICKS(NACK_TICKS), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lineS(lineS),
    .nackReq(nackReq), .strobes(strobes), .driveLow(driveLow)
  );

  sc_rx_datapath #(
    .DATA_W(DATA_W), .ITER_W(ITER_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobes(strobes),
    .limitEn(limitEn), .inhibitNack(inhibitNack), .maxIter(maxIter),
    .statusClr(statusClr), .lineS(lineS), .nackReq(nackReq),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .iterFlag(iterFlag)
  );

endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
  parameter int OVS        = 16,
  parameter int NACK_TICKS = 16
) (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic statusClr,
  input logic rxValid,
  input logic parityErr,
  input logic iterFlag,
  input logic driveLow
);

  localparam int CW = $clog2(2 * OVS + NACK_TICKS + 2);

  logic [CW-1:0] nackTicks;
  always_ff @(posedge clk) begin
    if (!rstN)          nackTicks <= '0;
    else if (!driveLow) nackTicks <= '0;
    else if (tick)      nackTicks <= nackTicks + 1'b1;
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R4
  drive_valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> !rxValid);

  // R4
  nack_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> (nackTicks <= CW'(NACK_TICKS)));

  // R5
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !statusClr) |=> parityErr);

  // R9
  iter_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iterFlag && !statusClr) |=> iterFlag);

  // R7
  iter_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(iterFlag) |-> (rxValid && parityErr));

endmodule

bind sc_char_rx sc_char_rx_chk #(.OVS(OVS), .NACK_TICKS(NACK_TICKS)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .statusClr(statusClr),
  .rxValid(rxValid), .parityErr(parityErr), .iterFlag(iterFlag),
  .driveLow(driveLow)
);

// File: tb/sc_char_rx_bench.sv
`timescale 1ns/1ps
module sc_char_rx_bench;

  localparam int OVS        = 16;
  localparam int NACK_TICKS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick;
  logic       senderLine = 1'b1;
  logic       lineIn;
  logic       limitEn = 1'b0;
  logic       inhibitNack = 1'b0;
  logic [2:0] maxIter = 3'd0;
  logic       statusClr = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, parityErr, iterFlag, driveLow;

  int checks = 0;
  int errors = 0;
  int tdiv = 1;
  int tcnt = 0;

  // bench model of the requirements
  logic [7:0] mData = 8'h00;
  int  mCnt = 0;
  bit  mPerr = 0;
  bit  mIter = 0;

  always #4 clk = ~clk;  // 125 MHz

  always_ff @(posedge clk) tcnt <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
  assign tick   = (tcnt == 0);
  assign lineIn = senderLine & ~driveLow;  // shared line, wired low

  sc_char_rx #(.OVS(OVS), .NACK_TICKS(NACK_TICKS)) u_sc_char_rx (
    .clk(clk), .rstN(rstN), .tick(tick), .lineIn(lineIn),
    .limitEn(limitEn), .inhibitNack(inhibitNack), .maxIter(maxIter),
    .statusClr(statusClr), .rxData(rxData), .rxValid(rxValid),
    .parityErr(parityErr), .iterFlag(iterFlag), .driveLow(driveLow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clrPulse(input string req);
    @(negedge clk) statusClr = 1'b1;
    @(negedge clk) statusClr = 1'b0;
    mPerr = 0; mIter = 0;
    @(negedge clk);
    chk(parityErr == 1'b0, req, "parityErr after clear", parityErr, 0);
    chk(iterFlag == 1'b0, req, "iterFlag after clear", iterFlag, 0);
  endtask

  // Send one character with a 3-ETU idle tail; compare with the model
  task automatic runChar(input logic [7:0] d, input bit bad,
                         input bit clrMode, input string tag);
    logic [9:0] bits;
    int etuC, total, validCnt, driveCnt, firstDrive, off;
    bit expNack, expValid, clrHeld, pAt, iAt;
    bits[0]   = 1'b0;
    bits[8:1] = d;
    bits[9]   = (^d) ^ bad;
    etuC = OVS * tdiv;
    total = 13 * etuC;
    validCnt = 0; driveCnt = 0; firstDrive = -1;
    expNack = 0; expValid = 0;
    clrHeld = clrMode; pAt = 0; iAt = 0;
    if (clrMode) begin mPerr = 0; mIter = 0; end
    if (!bad) begin
      mData = d; expValid = 1; mCnt = 0;
    end else begin
      mPerr = 1;
      if (inhibitNack) mData = d;
      else if (limitEn && mCnt >= int'(maxIter)) begin
        mData = d; expValid = 1; mIter = 1; mCnt = 0;
      end else begin
        expNack = 1;
        if (mCnt < 7) mCnt++;
      end
    end
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      if (rxValid) validCnt++;
      if (driveLow) begin
        driveCnt++;
        if (firstDrive < 0) firstDrive = c;
      end
      if (clrHeld && rxValid) begin
        pAt = parityErr; iAt = iterFlag; clrHeld = 0;
      end
      statusClr  = clrHeld;
      senderLine = (c / etuC < 10) ? bits[c / etuC] : 1'b1;
    end
    statusClr = 1'b0;
    chk(driveCnt == (expNack ? NACK_TICKS * tdiv : 0), tag,
        "NACK drive cycles", driveCnt, expNack ? NACK_TICKS * tdiv : 0);
    if (expNack) begin
      off = firstDrive - 9 * etuC;
      chk(off >= etuC && off <= etuC + 6 * tdiv, tag,
          "NACK start offset from parity bit", off, etuC);
    end
    chk(validCnt == int'(expValid), tag, "rxValid pulses", validCnt, int'(expValid));
    chk(rxData == mData, tag, "rxData", rxData, mData);
    chk(parityErr == mPerr, tag, "parityErr", parityErr, mPerr);
    chk(iterFlag == mIter, tag, "iterFlag", iterFlag, mIter);
    if (clrMode) begin
      chk(pAt == 1'b1, "R5", "parityErr with clear in same clock", pAt, 1);
      chk(iAt == 1'b1, "R9", "iterFlag with clear in same clock", iAt, 1);
    end
  endtask

  initial begin
    int vc, dc;
    logic [7:0] keep;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk(driveLow == 0 && rxValid == 0, "R1", "drive/valid in reset", {driveLow, rxValid}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(driveLow == 0 && rxValid == 0, "R1", "drive/valid after reset", {driveLow, rxValid}, 0);
    chk(parityErr == 0 && iterFlag == 0, "R1", "flags after reset", {parityErr, iterFlag}, 0);
    chk(rxData == 8'h00, "R1", "rxData after reset", rxData, 0);

    // R2 good characters
    runChar(8'hA5, 0, 0, "R2");
    runChar(8'h00, 0, 0, "R2");
    runChar(8'hFF, 0, 0, "R2");

    // R3 short glitch on idle line
    keep = rxData; vc = 0; dc = 0;
    for (int c = 0; c < 3 * OVS; c++) begin
      @(negedge clk);
      if (rxValid) vc++;
      if (driveLow) dc++;
      senderLine = (c < 4) ? 1'b0 : 1'b1;
    end
    chk(vc == 0 && dc == 0, "R3", "glitch valid/drive", vc + dc, 0);
    chk(rxData == keep, "R3", "glitch rxData", rxData, keep);
    runChar(8'h5A, 0, 0, "R3");

    // R4 plain NACK, R5 sticky error and clear
    runChar(8'h81, 1, 0, "R4");
    clrPulse("R5");

    // R6 inhibit: stored silently
    inhibitNack = 1'b1;
    runChar(8'h3C, 1, 0, "R6");
    inhibitNack = 1'b0;
    clrPulse("R5");

    // R7 cap of two
    limitEn = 1'b1; maxIter = 3'd2; mCnt = 0;
    runChar(8'h11, 0, 0, "R7");
    runChar(8'h22, 1, 0, "R7");
    runChar(8'h22, 1, 0, "R7");
    runChar(8'h22, 1, 0, "R7");
    clrPulse("R9");

    // R8 good character restarts the count
    runChar(8'h44, 1, 0, "R8");
    runChar(8'h45, 0, 0, "R8");
    runChar(8'h46, 1, 0, "R8");
    runChar(8'h46, 1, 0, "R8");
    runChar(8'h46, 1, 0, "R8");
    clrPulse("R9");

    // R10 zero cap
    maxIter = 3'd0;
    runChar(8'h77, 1, 0, "R10");

    // R11 limiting off
    limitEn = 1'b0;
    runChar(8'h12, 1, 0, "R11");
    runChar(8'h12, 1, 0, "R11");
    runChar(8'h12, 1, 0, "R11");
    runChar(8'h13, 0, 0, "R11");

    // clear held through a forced acceptance
    limitEn = 1'b1; maxIter = 3'd0;
    runChar(8'hC3, 1, 1, "R9");

    // random traffic; second half at half tick rate (R12)
    for (int i = 0; i < 120; i++) begin
      if (i == 60) tdiv = 2;
      if (i % 10 == 0) begin
        limitEn     = 1'($urandom % 2);
        inhibitNack = (($urandom % 8) == 0);
        maxIter     = 3'($urandom % 8);
      end
      if (i % 15 == 14) clrPulse("R5");
      runChar(8'($urandom), (($urandom % 10) < 4),
              0, (tdiv == 2) ? "R12" : "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule